// File: doc/BRIEF.md
# Banked Effective Address Generator

This block forms the 24-bit data address (an 8-bit bank above a 16-bit offset) that a 16-bit processor with banked memory needs for one operand access. A caller presents an addressing-mode code, up to three operand bytes and the current direct-page base, data bank, program bank, stack pointer and index registers, then pulses `start`. Modes that need no memory lookup finish in the next cycle. Modes that go through a pointer read that pointer one byte at a time from bank 0 through a synchronous byte-read port, then combine it with the data bank or with a post-index.

The result appears on `ea` together with a one-cycle `done` strobe. `busy` is high while pointer bytes are being fetched, and a `start` that arrives during that time is ignored. The index-width flag selects whether the full 16-bit X and Y registers take part in the sums or only their low bytes.

Top module: `bank_ea_gen`

## Requirements
- R1: Mode codes 0, 1 and 2 (absolute, absolute+X, absolute+Y) give `{dbank, opr1, opr0}`, with X or Y zero-extended and added across all 24 bits, so a carry out of the offset raises the bank.
- R2: Mode codes 3 and 4 (long, long+X) give `{opr2, opr1, opr0}`, with X added across all 24 bits in code 4.
- R3: Mode codes 5, 6 and 7 (direct, direct+X, direct+Y) give bank 0 and offset `opr0 + dpage` (+X or +Y), taken modulo 2^16.
- R4: Mode code 8 (stack-relative) gives bank 0 and offset `opr0 + stk` modulo 2^16.
- R5: Mode codes 9 and 10 (indirect, indirect-long) read a pointer in bank 0 at `opr0 + dpage`. The low byte comes first, the next bytes follow at offsets +1 and +2 modulo 2^16. Code 9 gives `{dbank, ptr16}` and code 10 gives the 24-bit pointer.
- R6: In mode code 11 X is added to `opr0 + dpage` before the pointer read, and the result is `{dbank, ptr16}`. In codes 12 (`{dbank, ptr16}`) and 13 (the 24-bit pointer) Y is added after the read, across all 24 bits.
- R7: Mode code 14 reads a 16-bit pointer at bank 0 offset `opr0 + stk` and gives `{dbank, ptr16} + Y` across 24 bits.
- R8: Mode code 15 (indirect jump) reads a 16-bit pointer at bank 0 offset `{opr1, opr0}` and gives `{pbank, ptr16}`. When the low byte sits at offset xxFF, the high byte comes from xx00 of the same page.
- R9: When `idx_narrow` is 1, only bits 7:0 of `xidx` and `yidx` are added, in every indexed mode.
- R10: Every pointer read addresses bank 0 and happens only while `busy` is high. `rd_data` is taken in the cycle after the matching `rd_en`.
- R11: `done` is high for exactly one cycle. For codes 0 to 8 it comes in the cycle after the `start` cycle. For 2-byte pointer modes it comes 5 cycles after the `start` cycle, and for 3-byte pointer modes (codes 10 and 13) 6 cycles after.
- R12: A `start` while `busy` is high is ignored: no extra `done`, and the running operation's `ea` is unchanged.
- R13: After a synchronous reset (`rst_n` low at a clock edge), `done`, `busy` and `rd_en` are 0 and `ea` is 0, even if a pointer fetch was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing-mode code (0 to 15) |
| opr0 | input | 8 | First operand byte |
| opr1 | input | 8 | Second operand byte |
| opr2 | input | 8 | Third operand byte (bank for long modes) |
| dpage | input | 16 | Direct-page base |
| dbank | input | 8 | Data bank |
| pbank | input | 8 | Program bank |
| stk | input | 16 | Stack pointer |
| xidx | input | 16 | X index register |
| yidx | input | 16 | Y index register |
| idx_narrow | input | 1 | 1 = 8-bit indices |
| rd_data | input | 8 | Byte returned the cycle after a read |
| rd_en | output | 1 | Pointer byte read request |
| rd_addr | output | 24 | Pointer byte address |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 24 | Computed bank:offset address |

## Verification
On every cycle the assertions check the following:
- `done` lasts a single cycle, and every end of `busy` comes with `done`.
- Pointer reads stay in bank 0 and never happen outside `busy`.
- Successive pointer bytes step by one offset, except in the jump mode, where they stay inside one page.
- Direct and stack-relative results land in bank 0.

Only the bench's scenarios can show that each mode's result arithmetic is correct: the carries into the bank, the 16-bit wraps, the narrowed indices and the page-wrap high byte. The same holds for the exact latency per mode, the ignored `start` during a fetch, and recovery from a reset in the middle of a fetch.

// File: rtl/bea_pkg.sv
// Shared types for the banked effective address generator.
// Assumes the mode code numbering listed in the brief.
package bea_pkg;

    typedef enum logic [3:0] {
        AM_ABS          = 4'd0,
        AM_ABS_X        = 4'd1,
        AM_ABS_Y        = 4'd2,
        AM_LONG         = 4'd3,
        AM_LONG_X       = 4'd4,
        AM_DIR          = 4'd5,
        AM_DIR_X        = 4'd6,
        AM_DIR_Y        = 4'd7,
        AM_STK          = 4'd8,
        AM_IND          = 4'd9,
        AM_IND_LONG     = 4'd10,
        AM_IDX_IND      = 4'd11,
        AM_IND_IDX      = 4'd12,
        AM_IND_LONG_IDX = 4'd13,
        AM_STK_IND_IDX  = 4'd14,
        AM_JMP_IND      = 4'd15
    } am_e;

    // True for modes that need a pointer fetched from memory.
    function automatic logic uses_ptr(am_e m);
        return m >= AM_IND;
    endfunction

    // True for modes whose pointer carries its own bank byte.
    function automatic logic long_ptr(am_e m);
        return (m == AM_IND_LONG) || (m == AM_IND_LONG_IDX);
    endfunction

endpackage

// File: rtl/bea_front.sv
// Address front end: forms the final address for modes without a pointer,
// and the bank-0 pointer location for pointer modes. Purely combinational.
// Assumes OFF_W = 2*BYTE_W and ADDR_W = 3*BYTE_W.
module bea_front
    import bea_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int OFF_W  = 2 * BYTE_W,
    parameter int ADDR_W = 3 * BYTE_W
) (
    input  am_e               mode,
    input  logic [BYTE_W-1:0] opr0,
    input  logic [BYTE_W-1:0] opr1,
    input  logic [BYTE_W-1:0] opr2,
    input  logic [OFF_W-1:0]  dpage,
    input  logic [BYTE_W-1:0] dbank,
    input  logic [OFF_W-1:0]  stk,
    input  logic [OFF_W-1:0]  xidx,
    input  logic [OFF_W-1:0]  yidx,
    input  logic              idx_narrow,
    output logic [ADDR_W-1:0] dir_ea,
    output logic [OFF_W-1:0]  ptr_base,
    output logic [OFF_W-1:0]  y_eff
);

    logic [OFF_W-1:0]  x_eff;
    logic [OFF_W-1:0]  op16;
    logic [OFF_W-1:0]  op8z;
    logic [OFF_W-1:0]  dsum;
    logic [ADDR_W-1:0] absb;

    // Index narrowing and operand widening.
    always_comb begin
        x_eff = idx_narrow ? OFF_W'(xidx[BYTE_W-1:0]) : xidx;
        y_eff = idx_narrow ? OFF_W'(yidx[BYTE_W-1:0]) : yidx;
        op16  = {opr1, opr0};
        op8z  = OFF_W'(opr0);
        dsum  = op8z + dpage;
        absb  = {dbank, op16};
    end

    // Result for modes without a pointer.
    always_comb begin
        dir_ea = absb;
        case (mode)
            AM_ABS:    dir_ea = absb;
            AM_ABS_X:  dir_ea = absb + ADDR_W'(x_eff);
            AM_ABS_Y:  dir_ea = absb + ADDR_W'(y_eff);
            AM_LONG:   dir_ea = {opr2, op16};
            AM_LONG_X: dir_ea = {opr2, op16} + ADDR_W'(x_eff);
            AM_DIR:    dir_ea = ADDR_W'(dsum);
            AM_DIR_X:  dir_ea = ADDR_W'(OFF_W'(dsum + x_eff));
            AM_DIR_Y:  dir_ea = ADDR_W'(OFF_W'(dsum + y_eff));
            AM_STK:    dir_ea = ADDR_W'(OFF_W'(op8z + stk));
            default:   dir_ea = absb;
        endcase
    end

    // Bank-0 location of the first pointer byte.
    always_comb begin
        case (mode)
            AM_IDX_IND:     ptr_base = dsum + x_eff;
            AM_STK_IND_IDX: ptr_base = op8z + stk;
            AM_JMP_IND:     ptr_base = op16;
            default:        ptr_base = dsum;
        endcase
    end

endmodule

// File: rtl/bea_ptr_fetch.sv
// Pointer fetch sequencer: reads 2 or 3 little-endian bytes from bank 0
// through a synchronous byte port (data valid the cycle after the request)
// and pulses fin one cycle after the last byte is captured.
// Assumes go is only raised while the sequencer is idle.
module bea_ptr_fetch #(
    parameter int BYTE_W = 8,
    parameter int OFF_W  = 2 * BYTE_W,
    parameter int ADDR_W = 3 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [OFF_W-1:0]  base,
    input  logic              three,
    input  logic              page_wrap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] ptr,
    output logic              fin
);

    typedef enum logic [1:0] {F_IDLE, F_RD, F_DRAIN} fst_e;

    fst_e                   st_q;
    logic [1:0]             k_q;
    logic [1:0]             last_q;
    logic [1:0]             idx_d_q;
    logic                   vld_q;
    logic                   wrap_q;
    logic [OFF_W-1:0]       base_q;
    logic [2:0][BYTE_W-1:0] byt_q;
    logic [OFF_W-1:0]       off;

    // Request address for byte k, honouring the same-page wrap.
    always_comb begin
        rd_en = (st_q == F_RD);
        if (wrap_q && (k_q == 2'd1))
            off = {base_q[OFF_W-1:BYTE_W], base_q[BYTE_W-1:0] + BYTE_W'(1)};
        else
            off = base_q + OFF_W'(k_q);
        rd_addr = ADDR_W'(off);
        ptr     = byt_q;
    end

    // Issue reads, capture returning bytes, and sequence the fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= F_IDLE;
            k_q     <= 2'd0;
            last_q  <= 2'd1;
            idx_d_q <= 2'd0;
            vld_q   <= 1'b0;
            wrap_q  <= 1'b0;
            base_q  <= '0;
            byt_q   <= '0;
            fin     <= 1'b0;
        end else begin
            vld_q   <= rd_en;
            idx_d_q <= k_q;
            fin     <= 1'b0;
            if (vld_q)
                byt_q[idx_d_q] <= rd_data;
            case (st_q)
                F_IDLE: begin
                    if (go) begin
                        base_q <= base;
                        wrap_q <= page_wrap;
                        last_q <= three ? 2'd2 : 2'd1;
                        k_q    <= 2'd0;
                        byt_q  <= '0;
                        st_q   <= F_RD;
                    end
                end
                F_RD: begin
                    if (k_q == last_q)
                        st_q <= F_DRAIN;
                    else
                        k_q <= k_q + 2'd1;
                end
                default: begin
                    st_q <= F_IDLE;
                    fin  <= 1'b1;
                end
            endcase
        end
    end

    // R10: every pointer read stays in bank 0.
    a_r10_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr[ADDR_W-1:OFF_W] == '0));

    // R5: consecutive pointer bytes sit at consecutive offsets.
    a_r5_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && !wrap_q) |->
        (rd_addr[OFF_W-1:0] == $past(rd_addr[OFF_W-1:0]) + OFF_W'(1)));

    // R8: with the jump wrap, the second byte stays in the first byte's page.
    a_r8_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && wrap_q) |->
        (rd_addr[OFF_W-1:BYTE_W] == $past(rd_addr[OFF_W-1:BYTE_W])));

endmodule

// File: rtl/bea_combine.sv
// Final combine: turns a fetched pointer into the result address
// (data bank prefix, own bank, program bank, optional post-index by Y).
// Purely combinational; inputs are held stable by the caller.
module bea_combine
    import bea_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int OFF_W  = 2 * BYTE_W,
    parameter int ADDR_W = 3 * BYTE_W
) (
    input  am_e               mode,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [BYTE_W-1:0] dbank,
    input  logic [BYTE_W-1:0] pbank,
    input  logic [OFF_W-1:0]  y_eff,
    output logic [ADDR_W-1:0] res
);

    logic [ADDR_W-1:0] dbp;

    // Pick the bank source and apply the post-index.
    always_comb begin
        dbp = {dbank, ptr[OFF_W-1:0]};
        case (mode)
            AM_IND_LONG:     res = ptr;
            AM_IND_IDX:      res = dbp + ADDR_W'(y_eff);
            AM_STK_IND_IDX:  res = dbp + ADDR_W'(y_eff);
            AM_IND_LONG_IDX: res = ptr + ADDR_W'(y_eff);
            AM_JMP_IND:      res = {pbank, ptr[OFF_W-1:0]};
            default:         res = dbp;
        endcase
    end

endmodule

// File: rtl/bank_ea_gen.sv
// Banked effective address generator top. Accepts a mode and operands on
// start, returns the 24-bit address with a one-cycle done. Pointer modes
// fetch from bank 0 while busy; start during busy is ignored.
// Assumes rd_data answers rd_en/rd_addr one cycle later.
module bank_ea_gen
    import bea_pkg::*;
#(
    parameter  int BYTE_W = 8,
    localparam int OFF_W  = 2 * BYTE_W,
    localparam int ADDR_W = 3 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [BYTE_W-1:0] opr0,
    input  logic [BYTE_W-1:0] opr1,
    input  logic [BYTE_W-1:0] opr2,
    input  logic [OFF_W-1:0]  dpage,
    input  logic [BYTE_W-1:0] dbank,
    input  logic [BYTE_W-1:0] pbank,
    input  logic [OFF_W-1:0]  stk,
    input  logic [OFF_W-1:0]  xidx,
    input  logic [OFF_W-1:0]  yidx,
    input  logic              idx_narrow,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] ea
);

    am_e               mode_in;
    am_e               mode_q;
    logic [BYTE_W-1:0] dbank_q;
    logic [BYTE_W-1:0] pbank_q;
    logic [OFF_W-1:0]  y_q;
    logic [ADDR_W-1:0] dir_ea;
    logic [OFF_W-1:0]  ptr_base;
    logic [OFF_W-1:0]  y_eff;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] final_ea;
    logic              fin;
    logic              accept;
    logic              go;

    // Accept decision for a new request.
    always_comb begin
        mode_in = am_e'(mode);
        accept  = start && !busy;
        go      = accept && uses_ptr(mode_in);
    end

    bea_front #(.BYTE_W(BYTE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_front (
        .mode       (mode_in),
        .opr0       (opr0),
        .opr1       (opr1),
        .opr2       (opr2),
        .dpage      (dpage),
        .dbank      (dbank),
        .stk        (stk),
        .xidx       (xidx),
        .yidx       (yidx),
        .idx_narrow (idx_narrow),
        .dir_ea     (dir_ea),
        .ptr_base   (ptr_base),
        .y_eff      (y_eff)
    );

    bea_ptr_fetch #(.BYTE_W(BYTE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .base      (ptr_base),
        .three     (long_ptr(mode_in)),
        .page_wrap (mode_in == AM_JMP_IND),
        .rd_data   (rd_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .ptr       (ptr),
        .fin       (fin)
    );

    bea_combine #(.BYTE_W(BYTE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_comb (
        .mode  (mode_q),
        .ptr   (ptr),
        .dbank (dbank_q),
        .pbank (pbank_q),
        .y_eff (y_q),
        .res   (final_ea)
    );

    // Request capture, result register and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            ea      <= '0;
            mode_q  <= AM_ABS;
            dbank_q <= '0;
            pbank_q <= '0;
            y_q     <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                mode_q  <= mode_in;
                dbank_q <= dbank;
                pbank_q <= pbank;
                y_q     <= y_eff;
                if (uses_ptr(mode_in)) begin
                    busy <= 1'b1;
                end else begin
                    ea   <= dir_ea;
                    done <= 1'b1;
                end
            end
            if (busy && fin) begin
                ea   <= final_ea;
                done <= 1'b1;
                busy <= 1'b0;
            end
        end
    end

    // R11: done lasts one cycle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: a fetch always ends with a result.
    a_r11_busy_end_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |-> done);

    // R10: reads happen only during a fetch.
    a_r10_read_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    // R3 and R4: direct and stack-relative results land in bank 0.
    a_r3_direct_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q inside {AM_DIR, AM_DIR_X, AM_DIR_Y, AM_STK})) |->
        (ea[ADDR_W-1:OFF_W] == '0));

endmodule

// File: tb/tb_bank_ea_gen.sv
module tb_bank_ea_gen;

    typedef struct packed {
        logic [3:0]  m;
        logic [7:0]  o0;
        logic [7:0]  o1;
        logic [7:0]  o2;
        logic [15:0] dp;
        logic [7:0]  db;
        logic [7:0]  pb;
        logic [15:0] s;
        logic [15:0] x;
        logic [15:0] y;
        logic        n;
    } vec_t;

    localparam int NV = 17;
    //                 m     o0     o1     o2     dp        db     pb     s         x         y         n
    localparam vec_t VEC [NV] = '{
        '{4'd0,  8'h34, 8'h12, 8'h00, 16'h0000, 8'h7E, 8'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R1
        '{4'd1,  8'hF0, 8'hFF, 8'h00, 16'h0000, 8'h7E, 8'h00, 16'h0000, 16'h0020, 16'h0000, 1'b0}, // R1 carry
        '{4'd2,  8'h00, 8'h20, 8'h00, 16'h0000, 8'h01, 8'h00, 16'h0000, 16'h0000, 16'h1234, 1'b1}, // R9
        '{4'd3,  8'h56, 8'h34, 8'hC0, 16'h0000, 8'h11, 8'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R2
        '{4'd4,  8'hFF, 8'hFF, 8'hC0, 16'h0000, 8'h11, 8'h00, 16'h0000, 16'h0001, 16'h0000, 1'b0}, // R2 carry
        '{4'd5,  8'h90, 8'h00, 8'h00, 16'hFF80, 8'h22, 8'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R3 wrap
        '{4'd6,  8'h10, 8'h00, 8'h00, 16'h0100, 8'h22, 8'h00, 16'h0000, 16'h01F0, 16'h0000, 1'b0}, // R3
        '{4'd7,  8'h10, 8'h00, 8'h00, 16'h0100, 8'h22, 8'h00, 16'h0000, 16'h0000, 16'hABCD, 1'b1}, // R9
        '{4'd8,  8'hF0, 8'h00, 8'h00, 16'h0000, 8'h22, 8'h00, 16'hFFF0, 16'h0000, 16'h0000, 1'b0}, // R4 wrap
        '{4'd9,  8'h00, 8'h00, 8'h00, 16'hFFFF, 8'h33, 8'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R5 wrap
        '{4'd10, 8'h20, 8'h00, 8'h00, 16'h1000, 8'h33, 8'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R5
        '{4'd11, 8'hF0, 8'h00, 8'h00, 16'h0000, 8'h44, 8'h00, 16'h0000, 16'hFF20, 16'h0000, 1'b0}, // R6
        '{4'd12, 8'h40, 8'h00, 8'h00, 16'h0200, 8'h12, 8'h00, 16'h0000, 16'h0000, 16'hFFFF, 1'b0}, // R6
        '{4'd13, 8'h41, 8'h00, 8'h00, 16'h0300, 8'h12, 8'h00, 16'h0000, 16'h0000, 16'h8000, 1'b0}, // R6
        '{4'd14, 8'h03, 8'h00, 8'h00, 16'h0000, 8'h55, 8'h00, 16'h01F0, 16'h0000, 16'h0010, 1'b0}, // R7
        '{4'd15, 8'h34, 8'h12, 8'h00, 16'h0000, 8'h55, 8'h05, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R8
        '{4'd15, 8'hFF, 8'h12, 8'h00, 16'h0000, 8'h55, 8'h05, 16'h0000, 16'h0000, 16'h0000, 1'b0}  // R8 wrap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  opr0 = '0, opr1 = '0, opr2 = '0;
    logic [15:0] dpage = '0;
    logic [7:0]  dbank = '0, pbank = '0;
    logic [15:0] stk = '0, xidx = '0, yidx = '0;
    logic        idx_narrow = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        rd_en;
    logic [23:0] rd_addr;
    logic        busy;
    logic        done;
    logic [23:0] ea;

    int n_chk = 0;
    int n_fail = 0;
    int bad_read = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bank_ea_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opr0(opr0), .opr1(opr1), .opr2(opr2), .dpage(dpage),
        .dbank(dbank), .pbank(pbank), .stk(stk), .xidx(xidx),
        .yidx(yidx), .idx_narrow(idx_narrow), .rd_data(rd_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy), .done(done), .ea(ea)
    );

    // Memory contents as a function of address.
    function automatic logic [7:0] mem_byte(logic [23:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[22:16], 1'b0} ^ 8'h3C;
    endfunction

    // Synchronous byte memory: data one cycle after the request.
    always @(posedge clk) rd_data <= mem_byte(rd_addr);

    // R10 monitor: reads outside bank 0 or outside busy.
    always @(negedge clk)
        if (rst_n && rd_en && (rd_addr[23:16] != 8'h00 || !busy)) bad_read++;

    function automatic logic [23:0] rd_ptr(logic [15:0] b, bit wrap);
        logic [15:0] a1;
        a1 = wrap ? {b[15:8], b[7:0] + 8'd1} : b + 16'd1;
        return {mem_byte({8'h00, b + 16'd2}), mem_byte({8'h00, a1}), mem_byte({8'h00, b})};
    endfunction

    // Expected address from the requirements.
    function automatic logic [23:0] model(vec_t v);
        logic [15:0] xi, yi, o16, dsum;
        logic [23:0] p;
        xi   = v.n ? {8'h00, v.x[7:0]} : v.x;
        yi   = v.n ? {8'h00, v.y[7:0]} : v.y;
        o16  = {v.o1, v.o0};
        dsum = {8'h00, v.o0} + v.dp;
        case (v.m)
            4'd0:  return {v.db, o16};
            4'd1:  return {v.db, o16} + {8'h00, xi};
            4'd2:  return {v.db, o16} + {8'h00, yi};
            4'd3:  return {v.o2, o16};
            4'd4:  return {v.o2, o16} + {8'h00, xi};
            4'd5:  return {8'h00, dsum};
            4'd6:  return {8'h00, 16'(dsum + xi)};
            4'd7:  return {8'h00, 16'(dsum + yi)};
            4'd8:  return {8'h00, 16'({8'h00, v.o0} + v.s)};
            4'd9:  begin p = rd_ptr(dsum, 0); return {v.db, p[15:0]}; end
            4'd10: return rd_ptr(dsum, 0);
            4'd11: begin p = rd_ptr(16'(dsum + xi), 0); return {v.db, p[15:0]}; end
            4'd12: begin p = rd_ptr(dsum, 0); return {v.db, p[15:0]} + {8'h00, yi}; end
            4'd13: begin p = rd_ptr(dsum, 0); return p + {8'h00, yi}; end
            4'd14: begin p = rd_ptr(16'({8'h00, v.o0} + v.s), 0); return {v.db, p[15:0]} + {8'h00, yi}; end
            default: begin p = rd_ptr(o16, 1); return {v.pb, p[15:0]}; end
        endcase
    endfunction

    function automatic int exp_lat(logic [3:0] m);
        if (m < 4'd9) return 1;
        if (m == 4'd10 || m == 4'd13) return 6;
        return 5;
    endfunction

    function automatic string req_of(vec_t v);
        if (v.n) return "R9";
        case (v.m)
            4'd0, 4'd1, 4'd2: return "R1";
            4'd3, 4'd4: return "R2";
            4'd5, 4'd6, 4'd7: return "R3";
            4'd8: return "R4";
            4'd9, 4'd10: return "R5";
            4'd11, 4'd12, 4'd13: return "R6";
            4'd14: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        mode = v.m; opr0 = v.o0; opr1 = v.o1; opr2 = v.o2;
        dpage = v.dp; dbank = v.db; pbank = v.pb; stk = v.s;
        xidx = v.x; yidx = v.y; idx_narrow = v.n;
    endtask

    // Start one vector, wait for done, return latency in cycles.
    task automatic launch(vec_t v, output int lat);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int lat;
        int dcount;
        repeat (3) @(negedge clk);
        // R13: reset state.
        chk(!done && !busy && !rd_en && ea == 24'h0, "R13", "reset outputs",
            {done, busy, rd_en, 5'd0, ea}, 32'h0);
        rst_n = 1'b1;

        // Table walk: every mode, result and latency.
        for (int i = 0; i < NV; i++) begin
            launch(VEC[i], lat);
            chk(ea == model(VEC[i]), req_of(VEC[i]), $sformatf("ea vec %0d", i),
                32'(ea), 32'(model(VEC[i])));
            chk(lat == exp_lat(VEC[i].m), "R11", $sformatf("latency vec %0d", i),
                32'(lat), 32'(exp_lat(VEC[i].m)));
            @(negedge clk);
            chk(!done, "R11", $sformatf("done width vec %0d", i), 32'(done), 32'h0);
        end

        // R12: start while busy is ignored.
        @(negedge clk);
        drive(VEC[10]);
        start = 1'b1;
        @(negedge clk);
        drive(VEC[0]);
        dcount = 0;
        for (int c = 0; c < 10; c++) begin
            if (c == 2) start = 1'b0;
            if (done) begin
                dcount++;
                chk(ea == model(VEC[10]), "R12", "ea of running op", 32'(ea), 32'(model(VEC[10])));
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(dcount == 1, "R12", "done count", 32'(dcount), 32'd1);

        // R13: reset in the middle of a fetch.
        @(negedge clk);
        drive(VEC[13]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!done && !busy && !rd_en && ea == 24'h0, "R13", "mid-fetch reset",
            {done, busy, rd_en, 5'd0, ea}, 32'h0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(!done && !busy, "R13", "no stale done", {30'd0, done, busy}, 32'h0);
        launch(VEC[16], lat);
        chk(ea == model(VEC[16]), "R8", "wrap after reset", 32'(ea), 32'(model(VEC[16])));

        // R10: all reads in bank 0 and inside busy.
        chk(bad_read == 0, "R10", "reads outside bank 0 or busy", 32'(bad_read), 32'd0);

        finished = 1;
        summary();
        $finish;
    end

endmodule